// File: doc/BRIEF.md
# Audio Parameter Tracker and Channel-Status Builder

This block samples two words from a register interface at a programmable interval: a packed audio format word and a status/category word. From the format word it decodes the channel count, the sample size and the sample rate. From those values and the status word it builds two channel-status words for an HDMI audio transmitter.

The sample rate is a base rate of 44.1 kHz or 48 kHz, scaled up by a multiplier field and down by a divisor field. The block works it out with a shift-add multiplier and a restoring divider, and raises a busy flag while they run. At the end of each poll it compares the five decoded parameters with the copy it holds. When any of them differs, it loads the new values and the new status words and pulses an update strobe for one cycle, so that the transmitter side knows to reprogram.

Top module: `audio_cs_tracker`

## Requirements
- R1: `chan_count` equals format bits 2:0 plus one.
- R2: Format bits 7:4 select the sample size on `sample_bits`: 0 gives 8, 1 gives 16, 2 gives 20, 3 gives 24, 4 gives 32. Every other code gives 16.
- R3: `sample_rate` equals base × (bits 13:11 + 1) / (bits 10:8 + 1), rounded down. The base is 44100 when format bit 14 is 1 and 48000 when it is 0.
- R4: In `cs_word1`, bit 0 is status bit 6, bit 1 is status bit 5, bit 2 is status bit 4 and bit 3 is status bit 3. Bits 15:8 hold status bits 15:8 (the category). Bits 7:4 and 23:16 are zero.
- R5: `cs_word1` bits 27:24 carry a rate code: 32000→3, 44100→0, 48000→2, 88200→8, 96000→A, 176400→C, 192000→E. Any other rate gives 0. Bits 31:28 are zero.
- R6: `cs_word2` bits 3:0 carry a size code: 16→2, 20→3, 24→B, and 0 for any other size. When status bit 1 is set, bits 18:16 hold 3'b101. All other bits are zero.
- R7: `update` goes high for exactly one cycle, in the same cycle that the new outputs first appear. It goes high only when the channels, rate, size, status byte (bits 7:0) or category differs from the stored copy. This includes status bits that do not map into either word.
- R8: During reset all outputs are zero. The stored channel count of zero can never be decoded, so the first poll after reset always raises `update`.
- R9: A poll tick occurs every `poll_period`+1 cycles, and the first one comes right after reset. Each accepted poll keeps `busy` high for 24 cycles. A tick that arrives while `busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_period | input | PW | Poll interval minus one, in cycles |
| fmt_word | input | 15 | Packed audio format word |
| stat_word | input | 16 | Status byte (7:0) and category (15:8) |
| busy | output | 1 | Rate computation in progress |
| update | output | 1 | One-cycle parameter change strobe |
| chan_count | output | 4 | Stored channel count |
| sample_bits | output | 6 | Stored sample size in bits |
| sample_rate | output | RW | Stored sample rate in Hz |
| cs_word1 | output | 32 | Channel-status word 1 |
| cs_word2 | output | 32 | Channel-status word 2 |

## Verification
The hardest case to reach is a tick that lands while the divider is still running. Reaching it takes a poll interval shorter than the 24-cycle computation, so the bench shortens `poll_period` and checks that the gap between busy periods stretches to the next free tick. A second subtle case is a change that alters only status bits with no place in either word. The bench flips those bits alone and expects the strobe while both status words stay the same. All 128 combinations of the rate fields are swept, and the expected rates are computed arithmetically.

// File: rtl/audio_cs_tracker.sv
module audio_cs_tracker #(
  parameter int PW = 16,
  parameter int RW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] poll_period,
  input  logic [14:0]   fmt_word,
  input  logic [15:0]   stat_word,
  output logic          busy,
  output logic          update,
  output logic [3:0]    chan_count,
  output logic [5:0]    sample_bits,
  output logic [RW-1:0] sample_rate,
  output logic [31:0]   cs_word1,
  output logic [31:0]   cs_word2
);
  localparam int KW = 4;
  localparam int DW = 4;
  localparam int CW = $clog2(RW + 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV, S_FIN} state_t;
  state_t st;

  logic [PW-1:0] pcnt;
  logic [CW-1:0] step;
  logic [14:0]   snap_fmt;
  logic [15:0]   snap_stat;
  logic [RW-1:0] mcand, quo;
  logic [KW-1:0] mplier;
  logic [DW:0]   rem, trial;
  logic [DW-1:0] dvsr;
  logic [7:0]    stat_q, cat_q;
  logic          tick, chg;
  logic [3:0]    d_chan, rcode, scode;
  logic [5:0]    d_bits;
  logic [31:0]   n_cs1, n_cs2;

  assign tick   = (pcnt == '0);
  assign busy   = (st != S_IDLE);
  assign dvsr   = {1'b0, snap_fmt[10:8]} + 4'd1;
  assign trial  = {rem[DW-1:0], quo[RW-1]};
  assign d_chan = {1'b0, snap_fmt[2:0]} + 4'd1;

  always_comb begin
    case (snap_fmt[7:4])
      4'd0:    d_bits = 6'd8;
      4'd2:    d_bits = 6'd20;
      4'd3:    d_bits = 6'd24;
      4'd4:    d_bits = 6'd32;
      default: d_bits = 6'd16;
    endcase
  end

  always_comb begin
    case (quo)
      RW'(32000):  rcode = 4'h3;
      RW'(48000):  rcode = 4'h2;
      RW'(88200):  rcode = 4'h8;
      RW'(96000):  rcode = 4'hA;
      RW'(176400): rcode = 4'hC;
      RW'(192000): rcode = 4'hE;
      default:     rcode = 4'h0;
    endcase
  end

  always_comb begin
    case (d_bits)
      6'd16:   scode = 4'h2;
      6'd20:   scode = 4'h3;
      6'd24:   scode = 4'hB;
      default: scode = 4'h0;
    endcase
  end

  assign n_cs1 = {4'h0, rcode, 8'h00, snap_stat[15:8], 4'h0,
                  snap_stat[3], snap_stat[4], snap_stat[5], snap_stat[6]};
  assign n_cs2 = {13'd0, snap_stat[1] ? 3'b101 : 3'b000, 12'd0, scode};

  assign chg = (d_chan != chan_count) || (quo != sample_rate) ||
               (d_bits != sample_bits) || (snap_stat[7:0] != stat_q) ||
               (snap_stat[15:8] != cat_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     pcnt <= '0;
    else if (tick)  pcnt <= poll_period;
    else            pcnt <= pcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      step        <= '0;
      snap_fmt    <= '0;
      snap_stat   <= '0;
      mcand       <= '0;
      mplier      <= '0;
      quo         <= '0;
      rem         <= '0;
      update      <= 1'b0;
      chan_count  <= '0;
      sample_bits <= '0;
      sample_rate <= '0;
      stat_q      <= '0;
      cat_q       <= '0;
      cs_word1    <= '0;
      cs_word2    <= '0;
    end else begin
      update <= 1'b0;
      case (st)
        S_IDLE: if (tick) begin
          snap_fmt  <= fmt_word;
          snap_stat <= stat_word;
          mcand     <= fmt_word[14] ? RW'(44100) : RW'(48000);
          mplier    <= {1'b0, fmt_word[13:11]} + 4'd1;
          quo       <= '0;
          step      <= '0;
          st        <= S_MUL;
        end
        S_MUL: begin
          if (mplier[0]) quo <= quo + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          step   <= step + 1'b1;
          if (step == CW'(KW - 1)) begin
            step <= '0;
            rem  <= '0;
            st   <= S_DIV;
          end
        end
        S_DIV: begin
          if (trial >= {1'b0, dvsr}) begin
            rem <= trial - {1'b0, dvsr};
            quo <= {quo[RW-2:0], 1'b1};
          end else begin
            rem <= trial;
            quo <= {quo[RW-2:0], 1'b0};
          end
          step <= step + 1'b1;
          if (step == CW'(RW - 1)) st <= S_FIN;
        end
        S_FIN: begin
          update      <= chg;
          chan_count  <= d_chan;
          sample_bits <= d_bits;
          sample_rate <= quo;
          stat_q      <= snap_stat[7:0];
          cat_q       <= snap_stat[15:8];
          cs_word1    <= n_cs1;
          cs_word2    <= n_cs2;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);
  a_r7_pulse_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> !busy);
  a_r7_words_move_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cs_word1) || !$stable(cs_word2)) |-> update);
  a_r9_busy_until_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_FIN) |=> busy);
  a_r3_rate_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    sample_rate <= RW'(384000));
endmodule

// File: tb/tb_audio_cs_tracker.sv
`timescale 1ns/1ps
module tb_audio_cs_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] poll_period = 16'd40;
  logic [14:0] fmt_word = '0;
  logic [15:0] stat_word = '0;
  logic        busy, update;
  logic [3:0]  chan_count;
  logic [5:0]  sample_bits;
  logic [18:0] sample_rate;
  logic [31:0] cs_word1, cs_word2;

  int total = 0, bad = 0;
  int p_ch = 0, p_rate = 0, p_bits = 0, p_st = 0, p_cat = 0;

  always #4 clk = ~clk;

  audio_cs_tracker dut (
    .clk(clk), .rst_n(rst_n), .poll_period(poll_period),
    .fmt_word(fmt_word), .stat_word(stat_word), .busy(busy), .update(update),
    .chan_count(chan_count), .sample_bits(sample_bits), .sample_rate(sample_rate),
    .cs_word1(cs_word1), .cs_word2(cs_word2));

  function automatic int e_bits(int f);
    case ((f >> 4) & 15)
      0: return 8;
      1: return 16;
      2: return 20;
      3: return 24;
      4: return 32;
      default: return 16;
    endcase
  endfunction

  function automatic int e_rate(int f);
    int base = ((f >> 14) & 1) ? 44100 : 48000;
    return base * (((f >> 11) & 7) + 1) / (((f >> 8) & 7) + 1);
  endfunction

  function automatic int e_rcode(int r);
    case (r)
      32000: return 3;
      48000: return 2;
      88200: return 8;
      96000: return 10;
      176400: return 12;
      192000: return 14;
      default: return 0;
    endcase
  endfunction

  function automatic int e_cs1(int s, int r);
    int v = 0;
    v |= (s >> 6) & 1;
    v |= ((s >> 5) & 1) << 1;
    v |= ((s >> 4) & 1) << 2;
    v |= ((s >> 3) & 1) << 3;
    v |= ((s >> 8) & 255) << 8;
    v |= e_rcode(r) << 24;
    return v;
  endfunction

  function automatic int e_cs2(int s, int b);
    int v = (b == 16) ? 2 : (b == 20) ? 3 : (b == 24) ? 11 : 0;
    if (s & 2) v |= 5 << 16;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_poll();
    while (busy !== 1'b1) @(negedge clk);
    while (busy !== 1'b0) @(negedge clk);
  endtask

  task automatic poll_and_check(int f, int s);
    int ch, r, b, chg;
    fmt_word  = 15'(f);
    stat_word = 16'(s);
    run_poll();
    ch = (f & 7) + 1; r = e_rate(f); b = e_bits(f);
    chg = (ch != p_ch) || (r != p_rate) || (b != p_bits) ||
          ((s & 255) != p_st) || (((s >> 8) & 255) != p_cat);
    chk("R1 channels", int'(chan_count), ch);
    chk("R2 size", int'(sample_bits), b);
    chk("R3 rate", int'(sample_rate), r);
    chk("R4/R5 cs1", int'(cs_word1), e_cs1(s, r));
    chk("R6 cs2", int'(cs_word2), e_cs2(s, b));
    chk("R7 update", int'(update), chg);
    p_ch = ch; p_rate = r; p_bits = b; p_st = s & 255; p_cat = (s >> 8) & 255;
    @(negedge clk);
    chk("R7 one cycle", int'(update), 0);
  endtask

  task automatic measure(output int hi, output int gap);
    while (busy !== 1'b1) @(negedge clk);
    hi = 0; gap = 0;
    while (busy === 1'b1) begin hi++; gap++; @(negedge clk); end
    while (busy !== 1'b1) begin gap++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, gap;
    fmt_word = 15'h0010; stat_word = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset update", int'(update), 0);
    chk("R8 reset cs1", int'(cs_word1), 0);
    chk("R8 reset cs2", int'(cs_word2), 0);
    chk("R8 reset rate", int'(sample_rate), 0);
    rst_n = 1'b1;
    poll_and_check(32'h0010, 0);
    poll_and_check(32'h0010, 0);
    for (int i = 0; i < 128; i++)
      poll_and_check((i << 8) | ((i % 16) << 4) | (i % 8), (i * 16'h1D3 + 5) & 16'hFFFF);
    poll_and_check(32'h0213, 16'h0300);
    poll_and_check(32'h0213, 16'h0380);
    poll_and_check(32'h0213, 16'h0381);
    poll_and_check(32'h0213, 16'h0381);
    poll_and_check(32'h1100, 16'h0002);
    run_poll(); run_poll();
    measure(hi, gap);
    chk("R9 busy length", hi, 24);
    chk("R9 poll interval", gap, 41);
    poll_period = 16'd9;
    run_poll(); run_poll();
    measure(hi, gap);
    chk("R9 busy length short period", hi, 24);
    chk("R9 dropped tick interval", gap, 30);
    run_poll();
    poll_and_check(32'h4A27, 16'h5A7C);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule